// File: doc/BRIEF.md
# Receive Queue with Fill Threshold

This block buffers characters coming out of a serial receiver until the host collects them. Each arriving character carries three error bits: parity, noise and framing. The error bits stay attached to their character for the whole time it is buffered. The oldest stored character sits in a holding register that the host reads. Its data bits appear on the data output, and its error bits appear on separate status outputs. A host read takes the character away and moves the next one forward.

The block keeps one fill count that covers the holding register and the queue together. The total capacity is the queue depth plus one. A three-bit code selects a fill level. When the count reaches that level, a threshold flag rises, and an interrupt output follows it if enabled. At the full-size level the count equals the queue depth, so one more character still fits without loss. A character that arrives when every place is taken is dropped, and a sticky overrun flag is raised. The host clears that flag with a one-cycle clear pulse.

Top module: `rx_thr_fifo`

## Requirements
- R1: After reset, `fill` is 0, `hold_valid` is 0, and `thr_flag`, `thr_irq` and `ovr_flag` are all 0.
- R2: Characters leave in the order they arrived. While `hold_valid` is 1, `hold_data` shows the oldest character and `hold_perr`/`hold_nerr`/`hold_ferr` show the three error bits that came with it. A `host_rd` pulse removes that character.
- R3: `fill` is the number of characters held, counting the holding register and the queue together. It updates one cycle after the push or read edge. Its maximum is DEPTH+1, which is 9 by default.
- R4: `thr_code` selects the fill level: 000→DEPTH/8, 001→DEPTH/4, 010→DEPTH/2, 011→3·DEPTH/4, 100→7·DEPTH/8. Codes 101, 110 and 111 all select DEPTH.
- R5: `thr_flag` is 1 exactly while `fill` is at or above the selected level. It drops again as soon as reads bring `fill` below that level.
- R6: `thr_irq` is 1 only while `thr_ie` is 1 and `thr_flag` is 1.
- R7: A push that arrives while `fill` equals DEPTH+1, with no read in the same cycle, is dropped and sets `ovr_flag`. With code 101, the push that takes `fill` from DEPTH to DEPTH+1 does not set `ovr_flag`.
- R8: An `ovr_clr` pulse clears `ovr_flag`. If a dropped push happens in the same cycle, the set wins.
- R9: A `host_rd` while the block is empty is ignored. A push and a read in the same cycle at full capacity are both accepted, and `fill` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A character is being pushed this cycle |
| rx_data | input | DW | Character bits of the push |
| rx_perr | input | 1 | Parity error bit of the push |
| rx_nerr | input | 1 | Noise error bit of the push |
| rx_ferr | input | 1 | Framing error bit of the push |
| host_rd | input | 1 | Host read of the holding register (removes the oldest character) |
| ovr_clr | input | 1 | Clear pulse for the overrun flag |
| thr_code | input | 3 | Fill-level selection code |
| thr_ie | input | 1 | Threshold interrupt enable |
| hold_valid | output | 1 | The holding register contains a character |
| hold_data | output | DW | Character bits of the oldest character (0 when empty) |
| hold_perr | output | 1 | Parity error bit of the oldest character |
| hold_nerr | output | 1 | Noise error bit of the oldest character |
| hold_ferr | output | 1 | Framing error bit of the oldest character |
| fill | output | $clog2(DEPTH+2) | Number of characters held |
| thr_flag | output | 1 | Fill has reached the selected level |
| thr_irq | output | 1 | Threshold interrupt |
| ovr_flag | output | 1 | Sticky overrun indication |

## Verification
A corrupted read or write pointer shows up on the next read. `hold_data` or the error outputs then disagree with the arrival order, and the bench compares every character of every sweep. A count that drifts by one shows up the cycle after the edge that caused it. It moves `fill`, shifts `thr_flag` by one character against the computed level, and either drops a push too early or lets a push through that should have set the overrun flag. The bench sweeps all eight threshold codes, filling to capacity and draining to empty, so each of these errors is seen within a few cycles.

// File: rtl/rx_thr_fifo.sv
module rx_thr_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 9
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rx_valid,
  input  logic [DW-1:0]                rx_data,
  input  logic                         rx_perr,
  input  logic                         rx_nerr,
  input  logic                         rx_ferr,
  input  logic                         host_rd,
  input  logic                         ovr_clr,
  input  logic [2:0]                   thr_code,
  input  logic                         thr_ie,
  output logic                         hold_valid,
  output logic [DW-1:0]                hold_data,
  output logic                         hold_perr,
  output logic                         hold_nerr,
  output logic                         hold_ferr,
  output logic [$clog2(DEPTH+2)-1:0]   fill,
  output logic                         thr_flag,
  output logic                         thr_irq,
  output logic                         ovr_flag
);
  localparam int CAP = DEPTH + 1;
  localparam int PW  = $clog2(CAP);
  localparam int FW  = $clog2(DEPTH + 2);
  localparam int EW  = DW + 3;

  logic [EW-1:0] mem [CAP];
  logic [PW-1:0] wp, rp;
  logic [FW-1:0] cnt, lvl;
  logic          ovr_q;

  wire is_full  = (cnt == FW'(CAP));
  wire do_pop   = host_rd && (cnt != '0);
  wire do_push  = rx_valid && (!is_full || do_pop);
  wire lose     = rx_valid && is_full && !do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(CAP - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    case (thr_code)
      3'd0:    lvl = FW'(DEPTH / 8);
      3'd1:    lvl = FW'(DEPTH / 4);
      3'd2:    lvl = FW'(DEPTH / 2);
      3'd3:    lvl = FW'(3 * DEPTH / 4);
      3'd4:    lvl = FW'(7 * DEPTH / 8);
      default: lvl = FW'(DEPTH);
    endcase
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= {rx_data, rx_perr, rx_nerr, rx_ferr};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      ovr_q <= 1'b0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
      if (lose)         ovr_q <= 1'b1;
      else if (ovr_clr) ovr_q <= 1'b0;
    end
  end

  assign hold_valid = (cnt != '0);
  assign hold_data  = hold_valid ? mem[rp][EW-1:3] : '0;
  assign hold_perr  = hold_valid & mem[rp][2];
  assign hold_nerr  = hold_valid & mem[rp][1];
  assign hold_ferr  = hold_valid & mem[rp][0];
  assign fill       = cnt;
  assign thr_flag   = (cnt >= lvl);
  assign thr_irq    = thr_ie & thr_flag;
  assign ovr_flag   = ovr_q;

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FW'(CAP)); // R3

  AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1))); // R3

  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(rx_valid && !host_rd && cnt == FW'(CAP))); // R7

  AST_OVR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_clr && !rx_valid) |=> !ovr_flag); // R8

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    thr_irq |-> (thr_ie && hold_valid)); // R6

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !rx_valid && cnt == '0) |=> (cnt == '0)); // R9

  AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && rx_valid && cnt == FW'(CAP)) |=> (cnt == FW'(CAP) && $stable(ovr_q))); // R9
endmodule

// File: tb/rx_thr_fifo_bench.sv
module rx_thr_fifo_bench;
  localparam int DEPTH = 8;
  localparam int DW    = 9;
  localparam int CAP   = DEPTH + 1;
  localparam int FW    = $clog2(DEPTH + 2);

  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, rx_perr = 0, rx_nerr = 0, rx_ferr = 0;
  logic [DW-1:0] rx_data = '0;
  logic host_rd = 0, ovr_clr = 0, thr_ie = 0;
  logic [2:0] thr_code = '0;
  logic hold_valid, hold_perr, hold_nerr, hold_ferr, thr_flag, thr_irq, ovr_flag;
  logic [DW-1:0] hold_data;
  logic [FW-1:0] fill;

  int n_run = 0, n_bad = 0, seq = 0;
  int model [$];
  bit done = 0;

  always #4ns clk = ~clk;

  rx_thr_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_thr_fifo (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_nerr(rx_nerr), .rx_ferr(rx_ferr), .host_rd(host_rd),
    .ovr_clr(ovr_clr), .thr_code(thr_code), .thr_ie(thr_ie),
    .hold_valid(hold_valid), .hold_data(hold_data), .hold_perr(hold_perr),
    .hold_nerr(hold_nerr), .hold_ferr(hold_ferr), .fill(fill),
    .thr_flag(thr_flag), .thr_irq(thr_irq), .ovr_flag(ovr_flag));

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int level(input int code);
    int num [8] = '{1, 2, 4, 6, 7, 8, 8, 8};
    return DEPTH * num[code] / 8;
  endfunction

  task automatic cyc(input bit push, input bit rd, input bit clr);
    int v;
    v = (seq * 173 + 29) & 12'hfff;
    seq++;
    rx_valid = push; host_rd = rd; ovr_clr = clr;
    rx_data = v[11:3]; rx_perr = v[2]; rx_nerr = v[1]; rx_ferr = v[0];
    if (rd && model.size() > 0) void'(model.pop_front());
    if (push && model.size() < CAP) model.push_back(v);
    @(posedge clk);
    @(negedge clk);
    rx_valid = 0; host_rd = 0; ovr_clr = 0;
  endtask

  task automatic chk_state(input int code);
    int n;
    n = model.size();
    chk("R3 fill", int'(fill), n);
    chk("R5 thr_flag", int'(thr_flag), int'(n >= level(code)));
    chk("R6 thr_irq", int'(thr_irq), int'(thr_ie && n >= level(code)));
  endtask

  task automatic chk_head();
    chk("R2 hold_valid", int'(hold_valid), int'(model.size() > 0));
    if (model.size() > 0) begin
      chk("R2 hold_data", int'(hold_data), model[0] >> 3);
      chk("R2 error bits", int'({hold_perr, hold_nerr, hold_ferr}), model[0] & 7);
    end
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      n_run++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 8; c++) begin
      rst_n = 0;
      thr_code = 3'(c);
      thr_ie = c[0] | (c == 4);
      model.delete();
      repeat (2) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 fill", int'(fill), 0);
      chk("R1 hold_valid", int'(hold_valid), 0);
      chk("R1 flags", int'({thr_flag, thr_irq, ovr_flag}), (c >= 0 && level(c) == 0) ? 6 : 0);
      chk("R4 level", level(c) <= DEPTH ? 1 : 0, 1);
      for (int i = 0; i < CAP; i++) begin
        cyc(1, 0, 0);
        chk_state(c);
        chk("R7 no overrun below capacity", int'(ovr_flag), 0);
        chk_head();
      end
      cyc(1, 0, 0);
      chk("R7 overrun set", int'(ovr_flag), 1);
      chk("R7 dropped char", int'(fill), CAP);
      chk_head();
      cyc(1, 0, 1);
      chk("R8 set wins over clear", int'(ovr_flag), 1);
      cyc(0, 0, 1);
      chk("R8 cleared", int'(ovr_flag), 0);
      cyc(1, 1, 0);
      chk("R9 swap at full keeps fill", int'(fill), CAP);
      chk("R9 swap no overrun", int'(ovr_flag), 0);
      chk_head();
      while (model.size() > 0) begin
        chk_head();
        cyc(0, 1, 0);
        chk_state(c);
      end
      cyc(0, 1, 0);
      chk("R9 read on empty", int'(fill), 0);
      chk("R9 empty hold_valid", int'(hold_valid), 0);
      for (int i = 0; i < DEPTH; i++) cyc(1, 0, 0);
      chk_state(c);
      cyc(1, 0, 0);
      chk("R7 push from DEPTH to capacity", int'(ovr_flag), 0);
      chk("R3 capacity", int'(fill), CAP);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule